// File: doc/BRIEF.md
# System Clock Ratio Tracker with Slip Recovery

This block runs entirely on the system clock. It counts system clock cycles between rising edges of an asynchronous word clock and sorts each count into one of three supported ratios: 256, 384 or 512 cycles per sample. The word clock passes through a two-flop synchroniser before its edges are detected. The block reports the confirmed ratio and a lock flag to the downstream oversampling logic.

While locked, a local frame counter of the confirmed length sets the output timing. It issues one output strobe per frame, at mid-frame. Each strobe carries the most recent sample taken from the incoming stream. On every word-clock edge the block compares the edge position with the local frame start:
- Small deviations are ignored.
- A large deviation realigns the frame counter to the edge. A late edge makes the block re-emit the previous output value. An early edge makes it skip the next sample.

Top module: `sysclk_ratio_tracker`

## Requirements
- R1: A measured period within 8 cycles either side (inclusive) of 256, 384 or 512 is classified as that ratio. `ratio_o` encodes 256 as 0, 384 as 1 and 512 as 2.
- R2: `ratio_o` and `lock_o` change only after two consecutive measurements fall in the same window. The first word-clock edge after reset starts timing but is not itself a measurement.
- R3: A measurement that falls in no window clears `lock_o` at that edge.
- R4: If more than 520 cycles pass without a word-clock rising edge, `lock_o` clears.
- R5: Under reset, `lock_o`, `sample_vld_o` and `sample_o` are 0 and `ratio_o` is 0.
- R6: While locked, `sample_vld_o` pulses once per local frame, carrying the last value accepted on `sample_i` with `sample_vld_i`. While unlocked it stays low.
- R7: A word-clock edge up to a quarter frame early or late relative to the local frame start causes no correction. The output values step by one sample per strobe.
- R8: An edge later than a quarter frame, up to half a frame, realigns the frame and produces an extra strobe that repeats the previous output value.
- R9: An edge earlier than a quarter frame (deviation past half, short of three quarters) realigns the frame and suppresses the next strobe, so one sample is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wclk_i | input | 1 | Word clock, asynchronous to clk_i |
| sample_i | input | SW | Incoming sample data |
| sample_vld_i | input | 1 | Marks a new sample on sample_i |
| ratio_o | output | 2 | Confirmed ratio code (0:256, 1:384, 2:512) |
| lock_o | output | 1 | Ratio confirmed and current |
| sample_o | output | SW | Realigned sample |
| sample_vld_o | output | 1 | Strobe for sample_o |

## Verification
The bench walks periods at each window edge: 248, 392, 376 and 520 must lock, while 247, 265 and 300 must not. A one-sided window check or an off-by-one counter would get one of these wrong. It drifts the word clock by 8 cycles per frame in both directions:
- Stopping exactly at a quarter-frame deviation must give a clean stream. A design that flags the boundary as a slip would repeat or drop there.
- One step further must yield exactly one repeat (late) or one drop (early). Swapped directions or a missing realignment would show as the wrong kind or count of glitch.

Other directed cases:
- A lone foreign-ratio frame must not move the ratio.
- A stopped word clock must release the lock only after the overrun limit.

// File: rtl/sckr_pkg.sv
package sckr_pkg;
  typedef enum logic [1:0] {
    RATIO_256 = 2'd0,
    RATIO_384 = 2'd1,
    RATIO_512 = 2'd2
  } ratio_e;

  localparam int unsigned BASE_LEN   = 256;
  localparam int unsigned STEP_LEN   = 128;
  localparam int unsigned NUM_RATIOS = 3;

  function automatic int unsigned frame_len(ratio_e r);
    return BASE_LEN + STEP_LEN * 32'(r);
  endfunction
endpackage

// File: rtl/sckr_wclk_sync.sv
module sckr_wclk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wclk_i,
  output logic rise_o
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], wclk_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/sckr_ratio_class.sv
module sckr_ratio_class
  import sckr_pkg::*;
#(
  parameter int unsigned CW  = 10,
  parameter int unsigned TOL = 8
) (
  input  logic [CW-1:0] count_i,
  output logic          match_o,
  output ratio_e        cls_o
);
  logic [NUM_RATIOS-1:0] hit;

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
    localparam logic [CW-1:0] LO = CW'(frame_len(ratio_e'(i)) - TOL);
    localparam logic [CW-1:0] HI = CW'(frame_len(ratio_e'(i)) + TOL);
    assign hit[i] = (count_i >= LO) && (count_i <= HI);
  end

  always_comb begin
    match_o = |hit;
    cls_o   = RATIO_256;
    if (hit[1]) cls_o = RATIO_384;
    if (hit[2]) cls_o = RATIO_512;
  end
endmodule

// File: rtl/sckr_period_meter.sv
module sckr_period_meter
  import sckr_pkg::*;
#(
  parameter int unsigned CW  = 10,
  parameter int unsigned TOL = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   rise_i,
  output ratio_e ratio_o,
  output logic   lock_o,
  output logic   relock_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] OVR_LIM = CW'(frame_len(RATIO_512) + TOL);

  logic [CW-1:0] cnt_q;
  logic          seen_q, prev_vld_q, lock_q;
  ratio_e        prev_cls_q, ratio_q;
  logic          match, measure, confirm, overrun;
  ratio_e        cls;

  sckr_ratio_class #(.CW(CW), .TOL(TOL)) u_class (
    .count_i (cnt_q),
    .match_o (match),
    .cls_o   (cls)
  );

  assign measure  = rise_i & seen_q;
  assign confirm  = measure & match & prev_vld_q & (prev_cls_q == cls);
  assign relock_o = confirm & (!lock_q | (ratio_q != cls));
  assign overrun  = cnt_q > OVR_LIM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      seen_q     <= 1'b0;
      prev_vld_q <= 1'b0;
      prev_cls_q <= RATIO_256;
      ratio_q    <= RATIO_256;
      lock_q     <= 1'b0;
    end else begin
      cnt_q  <= rise_i ? CW'(1) : ((cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1);
      seen_q <= seen_q | rise_i;
      if (measure) begin
        prev_vld_q <= match;
        prev_cls_q <= cls;
        if (!match) lock_q <= 1'b0;
        else if (confirm) begin
          lock_q  <= 1'b1;
          ratio_q <= cls;
        end
      end else if (overrun) begin
        lock_q     <= 1'b0;
        prev_vld_q <= 1'b0;
      end
    end
  end

  assign ratio_o = ratio_q;
  assign lock_o  = lock_q;

  a_r2_ratio_moves_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ratio_q) |-> lock_q);
  a_r3_lock_needs_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(measure && match));
  a_r4_overrun_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun |=> !lock_q);
endmodule

// File: rtl/sckr_frame_aligner.sv
module sckr_frame_aligner
  import sckr_pkg::*;
#(
  parameter int unsigned SW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          lock_i,
  input  ratio_e        ratio_i,
  input  logic          relock_i,
  input  logic [SW-1:0] sample_i,
  input  logic          sample_vld_i,
  output logic [SW-1:0] sample_o,
  output logic          sample_vld_o
);
  localparam int unsigned PW = $clog2(frame_len(RATIO_512));

  logic [PW-1:0] ph_q, len_m1, half, quarter, three_q;
  logic [SW-1:0] held_q;
  logic          drop_q;
  logic          chk, slip_late, slip_early, tick;
  int unsigned   len_full;

  always_comb begin
    len_full = frame_len(ratio_i);
    len_m1   = PW'(len_full - 1);
    half     = PW'(len_full / 2);
    quarter  = PW'(len_full / 4);
    three_q  = PW'(len_full - len_full / 4);
  end

  // ph_q at an edge is the deviation from the local frame start
  assign chk        = lock_i & rise_i & !relock_i;
  assign slip_late  = chk & (ph_q > quarter) & (ph_q <= half);
  assign slip_early = chk & (ph_q > half) & (ph_q < three_q);
  assign tick       = lock_i & !relock_i & (ph_q == half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else if (sample_vld_i) held_q <= sample_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q         <= '0;
      drop_q       <= 1'b0;
      sample_o     <= '0;
      sample_vld_o <= 1'b0;
    end else if (!lock_i) begin
      ph_q         <= '0;
      drop_q       <= 1'b0;
      sample_vld_o <= 1'b0;
    end else if (relock_i) begin
      ph_q         <= PW'(1);
      drop_q       <= 1'b0;
      sample_vld_o <= 1'b0;
    end else if (slip_late) begin
      ph_q         <= PW'(1);
      sample_vld_o <= 1'b1;        // repeat last output
    end else if (slip_early) begin
      ph_q         <= PW'(1);
      drop_q       <= 1'b1;        // skip next strobe
      sample_vld_o <= 1'b0;
    end else begin
      ph_q <= (ph_q == len_m1) ? '0 : ph_q + 1'b1;
      if (tick) begin
        sample_vld_o <= !drop_q;
        if (!drop_q) sample_o <= held_q;
        drop_q <= 1'b0;
      end else begin
        sample_vld_o <= 1'b0;
      end
    end
  end

  a_r6_quiet_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> !sample_vld_o);
  a_r8_repeat_holds_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_late |=> sample_vld_o && $stable(sample_o));
  a_r9_drop_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_early |=> !sample_vld_o);
  a_r7_phase_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && !relock_i) |-> ph_q <= len_m1);
endmodule

// File: rtl/sysclk_ratio_tracker.sv
module sysclk_ratio_tracker
  import sckr_pkg::*;
#(
  parameter int unsigned SW     = 24,
  parameter int unsigned CW     = 10,
  parameter int unsigned TOL    = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wclk_i,
  input  logic [SW-1:0] sample_i,
  input  logic          sample_vld_i,
  output logic [1:0]    ratio_o,
  output logic          lock_o,
  output logic [SW-1:0] sample_o,
  output logic          sample_vld_o
);
  logic   rise, lock, relock;
  ratio_e ratio;

  sckr_wclk_sync #(.STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wclk_i (wclk_i),
    .rise_o (rise)
  );

  sckr_period_meter #(.CW(CW), .TOL(TOL)) u_meter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise),
    .ratio_o  (ratio),
    .lock_o   (lock),
    .relock_o (relock)
  );

  sckr_frame_aligner #(.SW(SW)) u_align (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rise_i       (rise),
    .lock_i       (lock),
    .ratio_i      (ratio),
    .relock_i     (relock),
    .sample_i     (sample_i),
    .sample_vld_i (sample_vld_i),
    .sample_o     (sample_o),
    .sample_vld_o (sample_vld_o)
  );

  assign ratio_o = ratio;
  assign lock_o  = lock;
endmodule

// File: tb/tb_sysclk_ratio_tracker.sv
module tb_sysclk_ratio_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 24;

  logic clk = 1'b0, rst_ni = 1'b0, wclk = 1'b0, svld = 1'b0;
  logic [SW-1:0] sdat = '0;
  logic [1:0] ratio;
  logic lock, ovld;
  logic [SW-1:0] odat;

  sysclk_ratio_tracker #(.SW(SW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wclk_i(wclk), .sample_i(sdat),
    .sample_vld_i(svld), .ratio_o(ratio), .lock_o(lock),
    .sample_o(odat), .sample_vld_o(ovld)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int seq = 1;
  bit done = 0;

  // output stream monitor
  int n_tick = 0, n_rep = 0, n_drop = 0, n_bad = 0;
  int last_val = 0;
  bit have_last = 0;
  always @(negedge clk) begin
    if (rst_ni && ovld) begin
      n_tick++;
      if (have_last) begin
        if (int'(odat) == last_val) n_rep++;
        else if (int'(odat) == last_val + 2) n_drop++;
        else if (int'(odat) != last_val + 1) n_bad++;
      end
      last_val  = int'(odat);
      have_last = 1;
    end
  end

  task automatic clear_mon();
    n_tick = 0; n_rep = 0; n_drop = 0; n_bad = 0;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frame(input int len);
    wclk = 1'b1; svld = 1'b1; sdat = SW'(seq); seq++;
    @(negedge clk);
    svld = 1'b0;
    repeat (len/2 - 1) @(negedge clk);
    wclk = 1'b0;
    repeat (len - len/2) @(negedge clk);
  endtask

  task automatic frames(input int len, input int n);
    for (int i = 0; i < n; i++) frame(len);
  endtask

  typedef struct packed {
    int       len;
    int       nfr;
    logic     lk;
    logic [1:0] rt;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{256, 4, 1'b1, 2'd0},
    '{384, 4, 1'b1, 2'd1},
    '{512, 4, 1'b1, 2'd2},
    '{248, 4, 1'b1, 2'd0},
    '{392, 4, 1'b1, 2'd1},
    '{300, 3, 1'b0, 2'd0},
    '{520, 4, 1'b1, 2'd2},
    '{247, 3, 1'b0, 2'd0},
    '{265, 3, 1'b0, 2'd0},
    '{376, 4, 1'b1, 2'd1}
  };

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
    end
  end

  initial begin
    // R5 reset state
    repeat (3) @(negedge clk);
    check(lock == 0, "R5 lock", int'(lock), 0);
    check(ratio == 0, "R5 ratio", int'(ratio), 0);
    check(ovld == 0 && odat == 0, "R5 sample out", int'(odat), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R2 acquisition needs two matching measurements
    frame(384);
    check(lock == 0, "R2 after first edge", int'(lock), 0);
    frame(384);
    check(lock == 0, "R2 after one measurement", int'(lock), 0);
    frame(384);
    check(lock == 1 && ratio == 1, "R2 locked 384", int'(ratio), 1);
    frame(512);
    frame(384);
    check(lock == 1 && ratio == 1, "R2 lone 512 frame ignored", int'(ratio), 1);

    // R1 / R3 table walk
    for (int v = 0; v < 10; v++) begin
      frames(VECS[v].len, VECS[v].nfr);
      check(lock == VECS[v].lk, VECS[v].lk ? "R1 lock" : "R3 unlock", int'(lock), int'(VECS[v].lk));
      if (VECS[v].lk)
        check(ratio == VECS[v].rt, "R1 ratio", int'(ratio), int'(VECS[v].rt));
    end

    // R6 steady stream at 256
    frames(256, 4);
    clear_mon();
    frames(256, 10);
    check(n_tick == 10, "R6 strobes per frame", n_tick, 10);
    check(n_rep == 0 && n_drop == 0 && n_bad == 0, "R6 consecutive", n_rep + n_drop + n_bad, 0);
    check(last_val == seq - 1, "R6 latest sample", last_val, seq - 1);

    // R7 late drift up to a quarter frame
    clear_mon();
    frames(264, 8);
    frames(256, 2);
    check(n_rep == 0 && n_drop == 0 && n_bad == 0, "R7 late within quarter", n_rep + n_drop + n_bad, 0);
    // R8 one step beyond
    clear_mon();
    frames(264, 1);
    frames(256, 3);
    check(n_rep == 1, "R8 repeat count", n_rep, 1);
    check(n_drop == 0 && n_bad == 0, "R8 no other glitch", n_drop + n_bad, 0);
    check(lock == 1 && ratio == 0, "R8 lock kept", int'(lock), 1);

    // R7 early drift up to a quarter frame
    clear_mon();
    frames(248, 8);
    frames(256, 2);
    check(n_rep == 0 && n_drop == 0 && n_bad == 0, "R7 early within quarter", n_rep + n_drop + n_bad, 0);
    // R9 one step beyond
    clear_mon();
    frames(248, 1);
    frames(256, 3);
    check(n_drop == 1, "R9 drop count", n_drop, 1);
    check(n_rep == 0 && n_bad == 0, "R9 no other glitch", n_rep + n_bad, 0);

    // R3 / R6 unlocked gives no strobes
    frames(300, 3);
    check(lock == 0, "R3 mismatch unlock", int'(lock), 0);
    clear_mon();
    frames(300, 3);
    check(n_tick == 0, "R6 no strobe unlocked", n_tick, 0);

    // R4 stopped word clock
    frames(256, 4);
    check(lock == 1, "R4 relocked", int'(lock), 1);
    frame(256);
    repeat (240) @(negedge clk);
    check(lock == 1, "R4 still locked before limit", int'(lock), 1);
    repeat (100) @(negedge clk);
    check(lock == 0, "R4 overrun unlock", int'(lock), 0);

    done = 1;
    summary();
  end
endmodule